// File: doc/BRIEF.md
# Four-Plane Frame Buffer Write Datapath

This block forms the byte that each of four bit planes receives when a CPU writes into a planar frame buffer. Every plane stores one byte per address, with one bit per pixel. A CPU read strobe captures the addressed byte of all four planes into four latches. A CPU write strobe builds a new byte for each plane from one of three sources: the CPU byte after a right rotation, a 4-bit set/reset colour, or one CPU data bit copied across the byte. The byte is combined with the latch through a logical function. A per-bit mask then decides which bits take the new value and which keep the latched value. A 4-bit plane-enable mask decides which planes are written at all.

With this path, software can recolour one pixel in a single access. It reads the location to fill the latches, enables set/reset on all planes, and sets the bit mask to the single bit of that pixel. It then writes any CPU value. The write-data bytes and write enables are registered and appear one clock after the write strobe. Register programming, read modes and address translation are handled outside this block.

Top module: `planar_wr_path`

## Requirements
- R1: While reset is asserted, `plane_we` and `plane_wdata` are zero. Reset also clears the latches, so a write in latch-copy mode with no earlier read yields all-zero bytes.
- R2: A cycle with `cpu_rd` high loads latch p from `rd_data[8p+7:8p]` for every plane p. Without `cpu_rd`, the latches hold their value.
- R3: With `wr_mode`=0 (direct), the source byte for plane p is `sr_color[p]` copied to all 8 bits when `sr_enable[p]`=1. Otherwise it is the rotated CPU byte.
- R4: The CPU byte is rotated right by `rot_cnt` (0 to 7) before use in modes 0 and 3: result bit i = `cpu_data[(i+rot_cnt) mod 8]`.
- R5: In modes 0, 2 and 3, the source byte is combined with the plane's latch by `logic_fn`: 0 = pass the source, 1 = AND, 2 = OR, 3 = XOR. The combination comes before the bit mask.
- R6: For each bit, a mask bit of 1 takes the combined value and a 0 keeps the latch bit. Bit 7 is the leftmost pixel of the byte, so pixel x uses mask 0x80 >> x.
- R7: One cycle after `cpu_wr`, `plane_we` equals `map_mask` as sampled with the write. In every other cycle, `plane_we` is zero.
- R8: With `wr_mode`=1 (latch copy), each plane byte equals its latch. `bit_mask`, `logic_fn`, `cpu_data` and the set/reset inputs have no effect.
- R9: With `wr_mode`=2 (colour), the source byte for plane p is `cpu_data[p]` copied to all 8 bits. It then goes through the logical function and `bit_mask`.
- R10: With `wr_mode`=3 (masked colour), the source for plane p is `sr_color[p]` copied to all 8 bits. The effective mask is `bit_mask` AND the rotated CPU byte.
- R11: When `cpu_rd` and `cpu_wr` are high in the same cycle, the write uses the latch contents from before that read. The read's data is in the latches for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Read strobe: capture `rd_data` into the latches |
| rd_data | input | 32 | Addressed byte of each plane, plane p at bits 8p+7:8p |
| cpu_wr | input | 1 | Write strobe |
| cpu_data | input | 8 | CPU write byte |
| sr_color | input | 4 | Set/reset colour, one bit per plane |
| sr_enable | input | 4 | Per-plane set/reset select for mode 0 |
| rot_cnt | input | 3 | Right rotate count for the CPU byte |
| logic_fn | input | 2 | 0 pass, 1 AND, 2 OR, 3 XOR with the latch |
| wr_mode | input | 2 | 0 direct, 1 latch copy, 2 colour, 3 masked colour |
| bit_mask | input | 8 | Per-bit select: 1 new value, 0 latch |
| map_mask | input | 4 | Per-plane write enable |
| plane_wdata | output | 32 | Write byte for each plane, plane p at bits 8p+7:8p |
| plane_we | output | 4 | Per-plane write enable, one cycle after `cpu_wr` |

## Verification
A read and a write can fall in the same cycle. The write must then see the old latches while the read refills them. The bench first loads a known pattern, then raises `cpu_rd` with a second pattern together with a latch-copy write. It expects the first pattern at the output, and the second pattern from a following latch-copy write. The main sweep covers every mode, logical function and rotate count with pseudo-random latch, CPU, mask and colour values. Each result is compared with a bit-level model written in the bench.

// File: rtl/planar_wr_pkg.sv
package planar_wr_pkg;
   typedef enum logic [1:0] {
      WM_DIRECT = 2'd0,
      WM_LATCH  = 2'd1,
      WM_COLOR  = 2'd2,
      WM_MASKED = 2'd3
   } wmode_e;

   typedef enum logic [1:0] {
      LF_PASS = 2'd0,
      LF_AND  = 2'd1,
      LF_OR   = 2'd2,
      LF_XOR  = 2'd3
   } lfun_e;
endpackage

// File: rtl/wp_rotr.sv
module wp_rotr #(
   parameter int W      = 8,
   parameter bit ROT_EN = 1'b1,
   localparam int CW    = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [CW-1:0] cnt,
   output logic [W-1:0]  dout
);
   generate
      if (ROT_EN) begin : g_rot
         logic [2*W-1:0] dbl;
         always_comb begin
            dbl  = {din, din} >> cnt;
            dout = dbl[W-1:0];
         end
      end else begin : g_pass
         logic unused_cnt;
         assign unused_cnt = ^cnt;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/wp_latch_bank.sv
module wp_latch_bank #(
   parameter int PLANES = 4,
   parameter int W      = 8,
   localparam int TW    = PLANES * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] din,
   output logic [TW-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end
endmodule

// File: rtl/wp_plane_lane.sv
module wp_plane_lane
   import planar_wr_pkg::*;
#(
   parameter int W = 8
) (
   input  wmode_e       mode,
   input  lfun_e        fn,
   input  logic         sr_bit,
   input  logic         sr_sel,
   input  logic         cpu_bit,
   input  logic [W-1:0] rot_data,
   input  logic [W-1:0] latch,
   input  logic [W-1:0] bmask,
   output logic [W-1:0] wbyte
);
   logic [W-1:0] src, alu, msk;

   always_comb begin
      unique case (mode)
         WM_DIRECT: src = sr_sel ? {W{sr_bit}} : rot_data;
         WM_COLOR:  src = {W{cpu_bit}};
         WM_MASKED: src = {W{sr_bit}};
         default:   src = latch;
      endcase
   end

   always_comb begin
      unique case (fn)
         LF_AND:  alu = src & latch;
         LF_OR:   alu = src | latch;
         LF_XOR:  alu = src ^ latch;
         default: alu = src;
      endcase
   end

   assign msk   = (mode == WM_MASKED) ? (bmask & rot_data) : bmask;
   assign wbyte = (mode == WM_LATCH) ? latch : ((alu & msk) | (latch & ~msk));
endmodule

// File: rtl/planar_wr_path.sv
module planar_wr_path
   import planar_wr_pkg::*;
#(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8,
   parameter bit ROT_EN = 1'b1,
   localparam int TW    = PLANES * BYTE_W,
   localparam int CW    = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic [TW-1:0]     rd_data,
   input  logic              cpu_wr,
   input  logic [BYTE_W-1:0] cpu_data,
   input  logic [PLANES-1:0] sr_color,
   input  logic [PLANES-1:0] sr_enable,
   input  logic [CW-1:0]     rot_cnt,
   input  logic [1:0]        logic_fn,
   input  logic [1:0]        wr_mode,
   input  logic [BYTE_W-1:0] bit_mask,
   input  logic [PLANES-1:0] map_mask,
   output logic [TW-1:0]     plane_wdata,
   output logic [PLANES-1:0] plane_we
);
   initial begin
      assert (PLANES >= 1 && PLANES <= BYTE_W)
         else $error("PLANES must be between 1 and BYTE_W");
      assert (BYTE_W >= 2 && (1 << CW) == BYTE_W)
         else $error("BYTE_W must be a power of two");
   end

   logic [TW-1:0]     latch_q;
   logic [TW-1:0]     next_data;
   logic [BYTE_W-1:0] rot_data;
   wmode_e            mode;
   lfun_e             fn;

   assign mode = wmode_e'(wr_mode);
   assign fn   = lfun_e'(logic_fn);

   wp_latch_bank #(.PLANES(PLANES), .W(BYTE_W)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cpu_rd),
      .din  (rd_data),
      .q    (latch_q)
   );

   wp_rotr #(.W(BYTE_W), .ROT_EN(ROT_EN)) u_rot (
      .din (cpu_data),
      .cnt (rot_cnt),
      .dout(rot_data)
   );

   generate
      for (genvar p = 0; p < PLANES; p++) begin : g_lane
         wp_plane_lane #(.W(BYTE_W)) u_lane (
            .mode    (mode),
            .fn      (fn),
            .sr_bit  (sr_color[p]),
            .sr_sel  (sr_enable[p]),
            .cpu_bit (cpu_data[p]),
            .rot_data(rot_data),
            .latch   (latch_q[p*BYTE_W +: BYTE_W]),
            .bmask   (bit_mask),
            .wbyte   (next_data[p*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         plane_wdata <= '0;
         plane_we    <= '0;
      end else begin
         plane_we <= cpu_wr ? map_mask : '0;
         if (cpu_wr) plane_wdata <= next_data;
      end
   end
endmodule

// File: rtl/planar_wr_path_chk.sv
module planar_wr_path_chk #(
   parameter int PLANES = 4,
   parameter int BYTE_W = 8,
   localparam int TW    = PLANES * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic [TW-1:0]     rd_data,
   input logic              cpu_wr,
   input logic [1:0]        wr_mode,
   input logic [BYTE_W-1:0] bit_mask,
   input logic [PLANES-1:0] map_mask,
   input logic [TW-1:0]     latch_q,
   input logic [TW-1:0]     plane_wdata,
   input logic [PLANES-1:0] plane_we
);
   // R7
   we_follow_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wr |=> plane_we == $past(map_mask));

   // R7
   we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr |=> plane_we == '0);

   // R2
   latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> latch_q == $past(rd_data));

   // R2
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(latch_q));

   // R8 R11
   latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wr_mode == 2'd1) |=> plane_wdata == $past(latch_q));

   // R6
   mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wr_mode != 2'd1 && bit_mask == '0) |=> plane_wdata == $past(latch_q));
endmodule

bind planar_wr_path planar_wr_path_chk #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_rd     (cpu_rd),
   .rd_data    (rd_data),
   .cpu_wr     (cpu_wr),
   .wr_mode    (wr_mode),
   .bit_mask   (bit_mask),
   .map_mask   (map_mask),
   .latch_q    (latch_q),
   .plane_wdata(plane_wdata),
   .plane_we   (plane_we)
);

// File: tb/planar_wr_path_tb.sv
`timescale 1ns/1ps
module planar_wr_path_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [31:0] rd_data = '0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_data = '0;
   logic [3:0]  sr_color = '0, sr_enable = '0, map_mask = '0;
   logic [2:0]  rot_cnt = '0;
   logic [1:0]  logic_fn = '0, wr_mode = '0;
   logic [7:0]  bit_mask = '0;
   logic [31:0] plane_wdata;
   logic [3:0]  plane_we;

   int tests = 0, fails = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk = ~clk;

   planar_wr_path u_dut (.*);

   function automatic logic [31:0] rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   function automatic logic [31:0] model(input logic [1:0] m, input logic [1:0] f,
         input logic [2:0] r, input logic [3:0] src, input logic [3:0] sen,
         input logic [7:0] c, input logic [7:0] bm, input logic [31:0] lat);
      logic [31:0] res;
      logic [7:0] rc, s, a, mk, l;
      for (int i = 0; i < 8; i++) rc[i] = c[(i + r) % 8];
      for (int p = 0; p < 4; p++) begin
         l = lat[p*8 +: 8];
         case (m)
            2'd0: s = sen[p] ? (src[p] ? 8'hFF : 8'h00) : rc;
            2'd2: s = c[p] ? 8'hFF : 8'h00;
            default: s = src[p] ? 8'hFF : 8'h00;
         endcase
         case (f)
            2'd1: a = s & l;
            2'd2: a = s | l;
            2'd3: a = s ^ l;
            default: a = s;
         endcase
         mk = (m == 2'd3) ? (bm & rc) : bm;
         res[p*8 +: 8] = (m == 2'd1) ? l : ((a & mk) | (l & ~mk));
      end
      return res;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [31:0] v);
      @(negedge clk);
      cpu_rd = 1'b1; rd_data = v;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic do_write(input logic [1:0] m, input logic [1:0] f, input logic [2:0] r,
         input logic [3:0] src, input logic [3:0] sen, input logic [7:0] c,
         input logic [7:0] bm, input logic [3:0] mm);
      @(negedge clk);
      wr_mode = m; logic_fn = f; rot_cnt = r; sr_color = src; sr_enable = sen;
      cpu_data = c; bit_mask = bm; map_mask = mm; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] lat;
      logic [7:0]  c, bm;
      logic [3:0]  src, sen, mm;
      string tag;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 wdata", plane_wdata, 32'h0);
      check("R1 we", {28'h0, plane_we}, 32'h0);
      rst_n = 1'b1;
      // R1 latches cleared: latch copy without any read
      do_write(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'hFF, 8'hFF, 4'hF);
      check("R1 latch clear", plane_wdata, 32'h0);

      // R11 read and write in the same cycle
      do_read(32'hA5A5_3C3C);
      @(negedge clk);
      cpu_rd = 1'b1; rd_data = 32'h1122_3344;
      wr_mode = 2'd1; map_mask = 4'hF; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_wr = 1'b0;
      check("R11 old latch", plane_wdata, 32'hA5A5_3C3C);
      do_write(2'd1, 2'd3, 3'd5, 4'hF, 4'hF, 8'h00, 8'h00, 4'hF);
      check("R11 new latch R8", plane_wdata, 32'h1122_3344);

      // R7 enable timing: idle cycle after a write
      do_write(2'd0, 2'd0, 3'd0, 4'h0, 4'h0, 8'h00, 8'hFF, 4'h9);
      check("R7 we", {28'h0, plane_we}, 32'h9);
      @(negedge clk);
      check("R7 we idle", {28'h0, plane_we}, 32'h0);

      // R6 single pixel set, leftmost pixel = bit 7
      for (int x = 0; x < 8; x++) begin
         lat = rnd();
         src = 4'(x + 5);
         do_read(lat);
         do_write(2'd0, 2'd0, 3'd0, src, 4'hF, 8'h5A, 8'h80 >> x, 4'hF);
         for (int p = 0; p < 4; p++) lat[p*8 + 7 - x] = src[p];
         check("R6 pixel", plane_wdata, lat);
      end

      // R3 R4 R5 R8 R9 R10 sweep over mode, function, rotate
      for (int m = 0; m < 4; m++)
         for (int f = 0; f < 4; f++)
            for (int r = 0; r < 8; r++)
               for (int k = 0; k < 3; k++) begin
                  lat = rnd(); c = 8'(rnd()); bm = 8'(rnd());
                  src = 4'(rnd()); sen = 4'(rnd()); mm = 4'(rnd());
                  if (k == 0) bm = 8'hFF;
                  do_read(lat);
                  do_write(2'(m), 2'(f), 3'(r), src, sen, c, bm, mm);
                  case (m)
                     0: tag = "R3 R4 R5 direct";
                     1: tag = "R8 latch copy";
                     2: tag = "R9 R5 colour";
                     default: tag = "R10 R4 masked";
                  endcase
                  check(tag, plane_wdata,
                        model(2'(m), 2'(f), 3'(r), src, sen, c, bm, lat));
                  check("R7 map", {28'h0, plane_we}, {28'h0, mm});
               end

      // R2 latch holds without read: two writes share one read
      lat = 32'hF0E1_D2C3;
      do_read(lat);
      do_write(2'd0, 2'd2, 3'd0, 4'h0, 4'h0, 8'h0F, 8'hFF, 4'hF);
      do_write(2'd1, 2'd0, 3'd0, 4'h0, 4'h0, 8'h00, 8'h00, 4'hF);
      check("R2 hold", plane_wdata, lat);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule